// File: doc/BRIEF.md
# Serial NOR Flash Block-Erase Sequencer

This block sits on the host side of a single-bit SPI link to a serial NOR flash and erases one 64 KiB block when asked to. A one-cycle request carries a 24-bit address. The block then works through the whole sequence without further help from the system side:

1. It sends a write-enable frame.
2. It reads the status byte to confirm that the write-enable latch has been set.
3. It sends the erase frame, made of the opcode and the three address bytes.
4. It reads the status byte repeatedly until the busy flag drops.
5. It reads the status byte once more to confirm that the latch has cleared again.

The block ends with a one-cycle done pulse or a one-cycle fail pulse.

The SPI link runs in mode 0. The clock idles low, data is launched on the falling edge and data is captured on the rising edge. The serial clock is derived from the system clock by a parameter. Chip select is raised only after a whole byte, so the flash accepts the erase. Between two frames, chip select stays high for a programmable minimum number of system clocks. A poll limit bounds the time spent waiting on a flash that never finishes.

Top module: `spi_erase_seq`

## Requirements
- R1: After reset, flash_cs_n is 1, flash_sck is 0, and erase_done and erase_fail are 0.
- R2: flash_sck is 0 whenever flash_cs_n is 1, so the link idles in mode 0.
- R3: An accepted request first sends a frame holding only the byte 0x06. That frame is followed by a status frame: the byte 0x05, then one byte received on flash_miso with BUSY at bit 0 and WEL at bit 1, most significant bit first.
- R4: If WEL reads 0 in the status frame after write-enable, erase_fail pulses and no erase frame is sent.
- R5: The erase frame is the byte 0xD8, followed by erase_addr[23:16], [15:8] and [7:0], each byte sent most significant bit first, 32 bits in total.
- R6: flash_cs_n rises only after a whole number of bytes: the count of rising flash_sck edges in every frame is a multiple of 8.
- R7: After the erase frame, status frames repeat as long as BUSY reads 1.
- R8: When BUSY reads 0, exactly one more status frame follows. erase_done pulses if WEL is then 0. erase_fail pulses if WEL is still 1.
- R9: If BUSY reads 1 in MAX_POLLS consecutive polls, erase_fail pulses and no further frame is sent.
- R10: flash_cs_n stays high for at least CS_GAP system clocks before every falling edge.
- R11: Within a byte, flash_sck holds each level for exactly CLK_DIV system clocks.
- R12: A request arriving while a sequence runs is ignored. Each sequence ends in exactly one single-cycle pulse, either of erase_done or of erase_fail, never both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| erase_req | input | 1 | Start pulse, taken only when idle |
| erase_addr | input | 24 | Block address, captured with erase_req |
| erase_done | output | 1 | One-cycle pulse: block erased and latch cleared |
| erase_fail | output | 1 | One-cycle pulse: latch fault or poll timeout |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Serial clock, idle low |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The bound assertions check the electrical framing on every cycle:
- the serial clock stays low while chip select is high;
- chip select rises only on a byte boundary;
- the minimum chip-select gap is kept;
- each clock half-period lasts at least the divider;
- the done and fail pulses are exclusive and last one cycle.

The content of the frames can only be shown by the bench scenarios, which run against a behavioural flash model. That content covers the opcode order, the address bytes, how many polls are made, the outcome chosen for a missing latch, for a stuck latch and for a timeout, and whether a request is ignored in mid-sequence.

// File: rtl/spi_erase_pkg.sv
// Shared constants and state types of the block-erase sequencer.
// Assumes a flash whose status byte carries BUSY at bit 0 and WEL at bit 1.
package spi_erase_pkg;

    localparam int          ADDR_W      = 24;
    localparam logic [7:0]  OP_WREN     = 8'h06;
    localparam logic [7:0]  OP_RDSR     = 8'h05;
    localparam logic [7:0]  OP_BLKERASE = 8'hD8;
    localparam int          BIT_BUSY    = 0;
    localparam int          BIT_WEL     = 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_GAP,
        PH_XFER
    } phase_t;

    typedef enum logic [2:0] {
        ST_WREN,
        ST_WELCHK,
        ST_ERASE,
        ST_POLL,
        ST_FINAL
    } step_t;

endpackage

// File: rtl/spi_byte_engine.sv
// Mode-0 byte shifter: sends one byte MSB first and captures the
// last two bits returned on miso. SCLK toggles every CLK_DIV clocks.
// Assumes start only arrives while the engine is idle; done pulses one
// cycle after the falling edge that follows the eighth rising edge.
module spi_byte_engine #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [1:0] stat_lo,
    output logic       done
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic             active;
    logic             sck_q;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       sh;
    logic [1:0]       rx_q;
    logic             done_q;
    logic             tick;

    // Half-period strobe while a byte is in flight.
    assign tick = active && (div_cnt == DIV_LAST);

    // Bit sequencing, clock generation and capture of the returned bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck_q   <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            sh      <= '0;
            rx_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                sh      <= tx_byte;
                div_cnt <= '0;
                bit_idx <= '0;
                sck_q   <= 1'b0;
            end else if (active) begin
                if (tick) begin
                    div_cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            sh      <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = sh[7];
    assign stat_lo = rx_q;
    assign done    = done_q;

endmodule

// File: rtl/cs_gap_timer.sv
// Down-counter that holds chip select high for CS_GAP clocks.
// Assumes CS_GAP >= 1; expired is high on the last cycle of the gap.
module cs_gap_timer #(
    parameter int CS_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(CS_GAP - 1);

    logic [GAP_W-1:0] cnt;

    // Reload on every new gap, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= GAP_INIT;
        end else if (cnt != '0) begin
            cnt <= cnt - GAP_W'(1);
        end
    end

    assign expired = !load && (cnt == '0);

endmodule

// File: rtl/erase_ctrl.sv
// Frame sequencer: write-enable, latch check, erase, busy polling and a
// final latch check. Drives chip select and picks each byte to send.
// Assumes the byte engine reports the two low status bits at frame end.
module erase_ctrl
    import spi_erase_pkg::*;
#(
    parameter int MAX_POLLS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gap_expired,
    input  logic              eng_done,
    input  logic [1:0]        eng_stat,
    output logic              gap_load,
    output logic              eng_start,
    output logic [7:0]        eng_tx,
    output logic              cs_n,
    output logic              done,
    output logic              fail
);

    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

    phase_t            phase;
    step_t             step;
    logic [1:0]        idx;
    logic [1:0]        last_idx;
    logic              launch;
    logic [ADDR_W-1:0] addr_q;
    logic [POLL_W-1:0] poll_cnt;
    logic              done_q;
    logic              fail_q;
    logic              frame_end;

    // Number of bytes in the current frame, minus one.
    always_comb begin
        case (step)
            ST_WREN:  last_idx = 2'd0;
            ST_ERASE: last_idx = 2'd3;
            default:  last_idx = 2'd1;
        endcase
    end

    // Byte to send for the current step and byte position.
    always_comb begin
        case (step)
            ST_WREN: eng_tx = OP_WREN;
            ST_ERASE: begin
                case (idx)
                    2'd0:    eng_tx = OP_BLKERASE;
                    2'd1:    eng_tx = addr_q[23:16];
                    2'd2:    eng_tx = addr_q[15:8];
                    default: eng_tx = addr_q[7:0];
                endcase
            end
            default: eng_tx = (idx == 2'd0) ? OP_RDSR : 8'h00;
        endcase
    end

    assign frame_end = (phase == PH_XFER) && eng_done && (idx == last_idx);

    // Phase, step and outcome sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            step     <= ST_WREN;
            idx      <= '0;
            launch   <= 1'b0;
            addr_q   <= '0;
            poll_cnt <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        addr_q   <= addr;
                        step     <= ST_WREN;
                        poll_cnt <= '0;
                        phase    <= PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (gap_expired) begin
                        phase  <= PH_XFER;
                        idx    <= '0;
                        launch <= 1'b1;
                    end
                end
                default: begin
                    if (launch) begin
                        launch <= 1'b0;
                    end
                    if (eng_done && !frame_end) begin
                        idx    <= idx + 2'd1;
                        launch <= 1'b1;
                    end
                    if (frame_end) begin
                        phase <= PH_GAP;
                        case (step)
                            ST_WREN: step <= ST_WELCHK;
                            ST_WELCHK: begin
                                if (eng_stat[BIT_WEL]) begin
                                    step <= ST_ERASE;
                                end else begin
                                    fail_q <= 1'b1;
                                    phase  <= PH_IDLE;
                                end
                            end
                            ST_ERASE: begin
                                step     <= ST_POLL;
                                poll_cnt <= '0;
                            end
                            ST_POLL: begin
                                if (!eng_stat[BIT_BUSY]) begin
                                    step <= ST_FINAL;
                                end else if (poll_cnt == POLL_LAST) begin
                                    fail_q <= 1'b1;
                                    phase  <= PH_IDLE;
                                end else begin
                                    poll_cnt <= poll_cnt + POLL_W'(1);
                                end
                            end
                            default: begin
                                phase <= PH_IDLE;
                                if (eng_stat[BIT_WEL]) begin
                                    fail_q <= 1'b1;
                                end else begin
                                    done_q <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assign gap_load  = ((phase == PH_IDLE) && req) || frame_end;
    assign eng_start = (phase == PH_XFER) && launch;
    assign cs_n      = (phase != PH_XFER);
    assign done      = done_q;
    assign fail      = fail_q;

endmodule

// File: rtl/spi_erase_seq.sv
// Top of the block-erase sequencer: connects the frame sequencer, the
// chip-select gap timer and the mode-0 byte engine.
// Assumes CLK_DIV >= 1, CS_GAP >= 1 and MAX_POLLS >= 1.
module spi_erase_seq
    import spi_erase_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int CS_GAP    = 4,
    parameter int MAX_POLLS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic [ADDR_W-1:0] erase_addr,
    output logic              erase_done,
    output logic              erase_fail,
    output logic              flash_cs_n,
    output logic              flash_sck,
    output logic              flash_mosi,
    input  logic              flash_miso
);

    logic       gap_load;
    logic       gap_expired;
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [1:0] eng_stat;

    erase_ctrl #(
        .MAX_POLLS (MAX_POLLS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (erase_req),
        .addr        (erase_addr),
        .gap_expired (gap_expired),
        .eng_done    (eng_done),
        .eng_stat    (eng_stat),
        .gap_load    (gap_load),
        .eng_start   (eng_start),
        .eng_tx      (eng_tx),
        .cs_n        (flash_cs_n),
        .done        (erase_done),
        .fail        (erase_fail)
    );

    cs_gap_timer #(
        .CS_GAP (CS_GAP)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    spi_byte_engine #(
        .CLK_DIV (CLK_DIV)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (flash_miso),
        .sck     (flash_sck),
        .mosi    (flash_mosi),
        .stat_lo (eng_stat),
        .done    (eng_done)
    );

endmodule

// File: rtl/spi_erase_seq_chk.sv
// Protocol checker for the block-erase sequencer, bound to the top.
// Watches only the top-level pins; keeps its own small counters.
module spi_erase_seq_chk #(
    parameter int CLK_DIV = 2,
    parameter int CS_GAP  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic flash_cs_n,
    input logic flash_sck,
    input logic erase_done,
    input logic erase_fail
);

    logic        sck_q;
    logic [15:0] hi_run;
    logic [15:0] stab_run;
    logic [2:0]  rise_mod8;

    // Delayed clock, chip-select high run, level hold run, edges per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            hi_run    <= 16'hFFFF;
            stab_run  <= 16'hFFFF;
            rise_mod8 <= '0;
        end else begin
            sck_q <= flash_sck;
            if (!flash_cs_n) begin
                hi_run <= '0;
            end else if (hi_run != 16'hFFFF) begin
                hi_run <= hi_run + 16'd1;
            end
            if (flash_sck != sck_q) begin
                stab_run <= '0;
            end else if (stab_run != 16'hFFFF) begin
                stab_run <= stab_run + 16'd1;
            end
            if (flash_cs_n) begin
                rise_mod8 <= '0;
            end else if (flash_sck && !sck_q) begin
                rise_mod8 <= rise_mod8 + 3'd1;
            end
        end
    end

    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sck);

    p_byte_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |-> (rise_mod8 == 3'd0));

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_cs_n) |-> (int'(hi_run) >= CS_GAP));

    p_half_period_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_sck != sck_q) |-> (int'(stab_run) >= CLK_DIV - 1));

    p_outcome_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_done && erase_fail));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> !erase_done);

    p_fail_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fail |=> !erase_fail);

endmodule

bind spi_erase_seq spi_erase_seq_chk #(
    .CLK_DIV (CLK_DIV),
    .CS_GAP  (CS_GAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_cs_n (flash_cs_n),
    .flash_sck  (flash_sck),
    .erase_done (erase_done),
    .erase_fail (erase_fail)
);

// File: tb/sim_spi_erase_seq.sv
// Bench: behavioural serial flash model plus a per-clock monitor of the
// link, with scenario checks on frame contents and outcome.
module sim_spi_erase_seq;

    localparam int DIV  = 2;
    localparam int GAP  = 3;
    localparam int MAXP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        erase_req = 1'b0;
    logic [23:0] erase_addr = '0;
    logic        erase_done;
    logic        erase_fail;
    logic        flash_cs_n;
    logic        flash_sck;
    logic        flash_mosi;
    logic        flash_miso;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_erase_seq #(
        .CLK_DIV   (DIV),
        .CS_GAP    (GAP),
        .MAX_POLLS (MAXP)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_req  (erase_req),
        .erase_addr (erase_addr),
        .erase_done (erase_done),
        .erase_fail (erase_fail),
        .flash_cs_n (flash_cs_n),
        .flash_sck  (flash_sck),
        .flash_mosi (flash_mosi),
        .flash_miso (flash_miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural flash model ----------------
    int         bitcnt = 0;
    logic [7:0] cur = '0;
    logic [7:0] byte_q[$];
    logic [7:0] sts_sh = '0;
    logic       miso_r = 1'b0;
    logic       wel = 1'b0;
    int         busy_cnt = 0;
    bit         cfg_ignore = 0;
    bit         cfg_stuck = 0;
    int         cfg_busy = 0;
    logic [7:0] ops[$];
    logic [23:0] erased_addr = '0;
    int         erase_count = 0;
    int         bad_len = 0;

    assign flash_miso = miso_r;

    always @(negedge flash_cs_n) begin
        bitcnt = 0;
        byte_q.delete();
        miso_r = 1'b0;
    end

    always @(posedge flash_sck) begin
        if (flash_cs_n === 1'b0) begin
            cur = {cur[6:0], flash_mosi};
            bitcnt++;
            if (bitcnt % 8 == 0) byte_q.push_back(cur);
        end
    end

    always @(negedge flash_sck) begin
        if (flash_cs_n === 1'b0) begin
            if (bitcnt == 8 && byte_q.size() == 1 && byte_q[0] == 8'h05)
                sts_sh = {6'b0, wel, (busy_cnt > 0)};
            else
                sts_sh = {sts_sh[6:0], 1'b0};
            miso_r = sts_sh[7];
        end
    end

    always @(posedge flash_cs_n) begin
        if (byte_q.size() > 0) begin
            if (bitcnt % 8 != 0) bad_len++;
            ops.push_back(byte_q[0]);
            if (byte_q[0] == 8'h06 && byte_q.size() == 1) begin
                if (!cfg_ignore) wel = 1'b1;
            end else if (byte_q[0] == 8'hD8 && byte_q.size() == 4 && bitcnt == 32 && wel) begin
                erase_count++;
                erased_addr = {byte_q[1], byte_q[2], byte_q[3]};
                busy_cnt = cfg_busy;
                if (cfg_busy == 0) wel = cfg_stuck;
            end else if (byte_q[0] == 8'h05) begin
                if (busy_cnt > 0) begin
                    busy_cnt--;
                    if (busy_cnt == 0) wel = cfg_stuck;
                end
            end
        end
    end

    // ---------------- per-clock monitor ----------------
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;
    int   hi_run = 1000;
    int   half_run = 0;
    int   min_gap = 1000;
    int   min_half = 1000;
    int   pulses = 0;
    int   both = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(flash_cs_n && flash_sck), "R2", "sck high with cs_n high",
                int'(flash_sck), 0);
            if (erase_done || erase_fail) pulses++;
            if (erase_done && erase_fail) both++;
            if (flash_cs_n) begin
                hi_run++;
            end else begin
                if (prev_cs) begin
                    if (hi_run < min_gap) min_gap = hi_run;
                    half_run = 0;
                end else if (flash_sck != prev_sck) begin
                    if (half_run + 1 < min_half) min_half = half_run + 1;
                    half_run = 0;
                end else begin
                    half_run++;
                end
                hi_run = 0;
            end
            prev_sck = flash_sck;
            prev_cs  = flash_cs_n;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    task automatic run_case(input logic [23:0] a, input int nb, input bit ign,
                            input bit stk, input bit poke);
        logic [7:0] exp_ops[$];
        bit exp_done;
        int n;
        bit got_done;
        bit got_fail;
        cfg_ignore = ign;
        cfg_stuck = stk;
        cfg_busy = nb;
        wel = 1'b0;
        busy_cnt = 0;
        ops.delete();
        erase_count = 0;
        bad_len = 0;
        pulses = 0;
        both = 0;
        min_gap = 1000;
        min_half = 1000;
        exp_ops.push_back(8'h06);
        exp_ops.push_back(8'h05);
        if (!ign) begin
            exp_ops.push_back(8'hD8);
            if (nb >= MAXP) begin
                for (int i = 0; i < MAXP; i++) exp_ops.push_back(8'h05);
            end else begin
                for (int i = 0; i < nb + 2; i++) exp_ops.push_back(8'h05);
            end
        end
        exp_done = !ign && (nb < MAXP) && !stk;

        @(negedge clk);
        erase_req = 1'b1;
        erase_addr = a;
        @(negedge clk);
        erase_req = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            erase_req = 1'b1;
            erase_addr = ~a;
            @(negedge clk);
            erase_req = 1'b0;
        end
        n = 0;
        got_done = 0;
        got_fail = 0;
        while (!got_done && !got_fail && n < 20000) begin
            @(negedge clk);
            got_done = erase_done;
            got_fail = erase_fail;
            n++;
        end
        repeat (60) @(negedge clk);

        // R8 / R4 / R9: outcome of the sequence
        chk(got_done == exp_done && got_fail == !exp_done,
            ign ? "R4" : (nb >= MAXP ? "R9" : "R8"), "outcome done",
            int'(got_done), int'(exp_done));
        // R3 / R7: frame order and poll count
        chk(ops.size() == exp_ops.size(), "R7", "frame count",
            ops.size(), exp_ops.size());
        for (int i = 0; i < exp_ops.size() && i < ops.size(); i++)
            chk(ops[i] == exp_ops[i], (i < 2) ? "R3" : "R7", "frame opcode",
                int'(ops[i]), int'(exp_ops[i]));
        // R5: erase frame accepted and address bytes in order
        chk(erase_count == (ign ? 0 : 1), "R5", "erase frames accepted",
            erase_count, ign ? 0 : 1);
        if (!ign)
            chk(erased_addr == a, "R5", "erased address",
                int'(erased_addr), int'(a));
        // R6: whole bytes per frame
        chk(bad_len == 0, "R6", "frames ending mid-byte", bad_len, 0);
        // R10: chip-select gap
        chk(min_gap >= GAP, "R10", "min cs_n high clocks", min_gap, GAP);
        // R11: half period
        chk(min_half == DIV, "R11", "min sck level clocks", min_half, DIV);
        // R12: exactly one single-cycle outcome pulse
        chk(pulses == 1 && both == 0, "R12", "outcome pulses", pulses, 1);
        chk(flash_cs_n == 1'b1, "R12", "cs_n idle after end", int'(flash_cs_n), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(flash_cs_n == 1'b1, "R1", "cs_n in reset", int'(flash_cs_n), 1);
        chk(flash_sck == 1'b0, "R1", "sck in reset", int'(flash_sck), 0);
        chk(erase_done == 1'b0 && erase_fail == 1'b0, "R1", "outcome in reset",
            int'(erase_done) + int'(erase_fail), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(flash_cs_n == 1'b1 && flash_sck == 1'b0, "R1", "idle after reset",
            int'(flash_cs_n), 1);

        run_case(24'h123456, 3, 0, 0, 1);   // normal, request poke ignored (R12)
        run_case(24'hABCDEF, 0, 0, 0, 0);   // ready on first poll (R7, R8)
        run_case(24'h010000, 0, 1, 0, 0);   // latch never set (R4)
        run_case(24'hFF0000, 10, 0, 0, 0);  // poll timeout (R9)
        run_case(24'h3F0000, MAXP - 1, 0, 0, 0); // last allowed poll (R9 boundary)
        run_case(24'h200000, 2, 0, 1, 0);   // latch stuck after erase (R8)

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule